// File: doc/BRIEF.md
# Shared-Memory Command Ring Consumer

This block is the device end of a circular command queue that a producer keeps in a shared memory of 32-bit words. The queue's bounds and pointers are stored in that same memory rather than inside the block. Words 0 to 3 of the region hold, as byte offsets from the region's start, the lower bound (word 0), the upper bound (word 1), the producer's write pointer (word 2) and the consumer's read pointer (word 3). The producer stores a word at its write pointer, then advances the pointer. A pointer that steps onto the upper bound goes back to the lower bound. When advancing the write pointer would make it equal the read pointer, the producer must wait, so one slot is always left empty.

Each time the block polls, it reads all four header words. A read pointer that differs from the write pointer means work is pending. The block then fetches the word at the read pointer and checks its opcode field. It offers the word on a valid/ready stream. Once the word is accepted, it writes the advanced read pointer back to word 3. Consumption runs only while a configuration-done level is high. An opcode that is not recognised stops the block with a sticky error. A sync request holds busy high until the consumer has caught up with the producer. The memory port is a single synchronous port with one cycle of read latency.

Top module: `ring_consumer`

## Requirements
- R1: After synchronous reset, cmd_valid, busy, err, mem_en and mem_we are all 0.
- R2: Every poll reads header words 0..3 afresh. A write-pointer update by the producer is therefore picked up with no other signal. When word 2 equals word 3, no word is emitted and memory is not written.
- R3: When word 2 differs from word 3, the word at byte offset word3 (word index word3/4) is fetched and emitted on cmd_data. Words come out in the order the producer stored them.
- R4: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_data does not change.
- R5: Word 3 is written only after a word has been accepted (cmd_valid and cmd_ready both high at a clock edge). The write goes to word index 3 and carries the old read pointer plus 4.
- R6: If the read pointer plus 4 equals the upper bound (word 1), the value written back is the lower bound (word 0).
- R7: While cfg_done is 0, no new poll starts, no word is emitted and word 3 stays unchanged.
- R8: A word's opcode is bits [31:24]. Values below NUM_OPS (default 16, so 0x0F is the highest valid value) are recognised. Any other value sets err, and the word is neither emitted nor consumed, so word 3 keeps pointing at it.
- R9: err stays set while cfg_done is 1 and no further words are consumed. Lowering cfg_done clears err, and raising cfg_done again resumes consumption.
- R10: A one-cycle sync_req pulse raises busy on the next cycle. busy stays high until a poll that started after the request finds word 2 equal to word 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Level that enables consumption and clears err while low |
| sync_req | input | 1 | One-cycle request to report when the queue is drained |
| busy | output | 1 | High from a sync request until the queue is seen empty |
| err | output | 1 | Sticky unrecognised-opcode flag |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write qualifier |
| mem_addr | output | AW | Memory word index |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read strobe |
| cmd_valid | output | 1 | Fetched command word is offered |
| cmd_ready | input | 1 | Downstream accepts the offered word |
| cmd_data | output | DW | Fetched command word |

## Verification
The bench wraps a short ring of eight slots around its upper bound while the queue is full. A design that compared against the wrong bound, or wrapped one word late, would write a wrong read pointer, and the per-write comparison catches that value. It holds cmd_ready low in a pseudo-random pattern, which exposes a design that writes the pointer back before acceptance or changes data while stalled. It places opcode 0x10 next to the valid limit 0x0F. It then checks that the bad word is neither emitted nor skipped, and that err clears only through cfg_done. Sync requests are issued both with words pending and on an empty queue, so a busy flag that drops on a stale header read shows up as words still queued when busy falls.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HWAIT,
    ST_CHECK,
    ST_FWAIT,
    ST_EMIT
  } ring_st_t;

  // header word positions: the producer decodes this order
  localparam int HDR_MIN    = 0;
  localparam int HDR_MAX    = 1;
  localparam int HDR_NEXT   = 2;
  localparam int HDR_STOP   = 3;
  localparam int HDR_WORDS  = 4;
  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/ring_hdr_regs.sv
module ring_hdr_regs
  import ring_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [1:0]    cap_idx,
  input  logic [DW-1:0] cap_data,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic [DW-1:0] wr_ptr,
  output logic [DW-1:0] rd_ptr
);
  logic [DW-1:0] hdr [HDR_WORDS];

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (rst) begin
        hdr[g] <= '0;
      end else if (cap_en && (cap_idx == 2'(g))) begin
        hdr[g] <= cap_data;
      end
    end
  end

  assign lo     = hdr[HDR_MIN];
  assign hi     = hdr[HDR_MAX];
  assign wr_ptr = hdr[HDR_NEXT];
  assign rd_ptr = hdr[HDR_STOP];
endmodule

// File: rtl/ring_ptr_adv.sv
module ring_ptr_adv
  import ring_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic [DW-1:0] nxt
);
  logic [DW-1:0] inc;

  always_comb begin
    inc = cur + DW'(WORD_BYTES);
    nxt = (inc == hi) ? lo : inc;
  end
endmodule

// File: rtl/ring_op_check.sv
module ring_op_check #(
  parameter int OPW     = 8,
  parameter int NUM_OPS = 16
) (
  input  logic [OPW-1:0] op,
  output logic           ok
);
  localparam logic [OPW:0] LIMIT = (OPW+1)'(NUM_OPS);

  assign ok = ({1'b0, op} < LIMIT);
endmodule

// File: rtl/ring_sync_tracker.sv
module ring_sync_tracker (
  input  logic clk,
  input  logic rst,
  input  logic sync_req,
  input  logic poll_start,
  input  logic empty_seen,
  output logic busy
);
  logic pend_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (sync_req) begin
      pend_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (empty_seen && armed_q) begin
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (poll_start) begin
      armed_q <= pend_q;
    end
  end

  assign busy = pend_q;
endmodule

// File: rtl/ring_consumer.sv
module ring_consumer
  import ring_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int OP_LSB  = 24,
  parameter int OPW     = 8,
  parameter int NUM_OPS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_done,
  input  logic          sync_req,
  output logic          busy,
  output logic          err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [DW-1:0] cmd_data
);
  localparam int IDX_LSB = $clog2(WORD_BYTES);

  ring_st_t      st;
  logic [1:0]    idx;
  logic          rd_vld;
  logic [DW-1:0] lo, hi, wr_ptr, rd_ptr, rd_adv;
  logic          op_ok;
  logic          poll_start, empty_seen, hdr_cap;

  assign poll_start = (st == ST_IDLE) && cfg_done && !err;
  assign empty_seen = (st == ST_CHECK) && (wr_ptr == rd_ptr);
  assign hdr_cap    = (st == ST_HWAIT) && rd_vld;

  ring_hdr_regs #(.DW(DW)) u_hdr (
    .clk(clk), .rst(rst), .cap_en(hdr_cap), .cap_idx(idx),
    .cap_data(mem_rdata), .lo(lo), .hi(hi), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  ring_ptr_adv #(.DW(DW)) u_adv (
    .cur(rd_ptr), .lo(lo), .hi(hi), .nxt(rd_adv)
  );

  ring_op_check #(.OPW(OPW), .NUM_OPS(NUM_OPS)) u_op (
    .op(mem_rdata[OP_LSB +: OPW]), .ok(op_ok)
  );

  ring_sync_tracker u_sync (
    .clk(clk), .rst(rst), .sync_req(sync_req), .poll_start(poll_start),
    .empty_seen(empty_seen), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      rd_vld    <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
      err       <= 1'b0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      rd_vld <= mem_en && !mem_we;
      if (!cfg_done) err <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (poll_start) begin
            mem_en   <= 1'b1;
            mem_addr <= AW'(HDR_MIN);
            idx      <= '0;
            st       <= ST_HWAIT;
          end
        end
        ST_HWAIT: begin
          if (rd_vld) begin
            if (idx == 2'(HDR_STOP)) begin
              st <= ST_CHECK;
            end else begin
              idx      <= idx + 2'd1;
              mem_en   <= 1'b1;
              mem_addr <= AW'(idx) + AW'(1);
            end
          end
        end
        ST_CHECK: begin
          if (wr_ptr == rd_ptr) begin
            st <= ST_IDLE;
          end else begin
            mem_en   <= 1'b1;
            mem_addr <= rd_ptr[IDX_LSB +: AW];
            st       <= ST_FWAIT;
          end
        end
        ST_FWAIT: begin
          if (rd_vld) begin
            if (op_ok) begin
              cmd_valid <= 1'b1;
              cmd_data  <= mem_rdata;
              st        <= ST_EMIT;
            end else begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end
          end
        end
        ST_EMIT: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= AW'(HDR_STOP);
            mem_wdata <= rd_adv;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_consumer_chk.sv
module ring_consumer_chk #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_done,
  input logic          sync_req,
  input logic          busy,
  input logic          err,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [DW-1:0] cmd_data
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  assert_wb_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(cmd_valid && cmd_ready));

  assert_wb_target_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_en && (mem_addr == AW'(3))));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> !cmd_valid);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err && cfg_done) |=> err);

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sync_req));
endmodule

bind ring_consumer ring_consumer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_done(cfg_done), .sync_req(sync_req),
  .busy(busy), .err(err), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data)
);

// File: tb/tb_ring_consumer.sv
module tb_ring_consumer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_done = 1'b0;
  logic sync_req = 1'b0;
  logic busy, err, mem_en, mem_we, cmd_valid;
  logic cmd_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, cmd_data;
  logic [DW-1:0] mem_rdata = '0;

  ring_consumer dut (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .sync_req(sync_req),
    .busy(busy), .err(err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // shared memory model
  logic [DW-1:0] ram [2**AW];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] = mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int quiet_hits = 0;
  bit quiet = 1'b0;
  bit stall_en = 1'b0;
  bit hold_chk = 1'b0;
  logic [DW-1:0] held;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] ref_min, ref_max, ref_stop;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] step(input logic [DW-1:0] p);
    logic [DW-1:0] n;
    n = p + 4;
    if (n == ref_max) n = ref_min;
    return n;
  endfunction

  // reference model compared every clock
  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(1'b0, "watchdog", 32'(cyc), 32'(WATCHDOG));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (!rst) begin
      if (hold_chk)
        check(cmd_valid && (cmd_data == held), "R4 hold while stalled", cmd_data, held);
      if (mem_we)
        check((mem_addr == AW'(3)) && (mem_wdata == ref_stop), "R5/R6 writeback",
              mem_wdata, ref_stop);
      if (quiet && cmd_valid) quiet_hits++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = stall_en ? lfsr[0] : 1'b1;
      hold_chk = cmd_valid && !cmd_ready;
      held = cmd_data;
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected word", cmd_data, '0);
        end else begin
          check(cmd_data == exp_q[0], "R3 word order", cmd_data, exp_q[0]);
          void'(exp_q.pop_front());
        end
        ref_stop = step(ref_stop);
      end
    end
  end

  task automatic push_raw(input logic [DW-1:0] w);
    logic [DW-1:0] nx;
    nx = ram[2];
    ram[nx[AW+1:2]] = w;
    nx = nx + 4;
    if (nx == ram[1]) nx = ram[0];
    ram[2] = nx;
  endtask

  task automatic push(input logic [DW-1:0] w);
    logic [DW-1:0] nx;
    nx = ram[2] + 4;
    if (nx == ram[1]) nx = ram[0];
    while (nx == ram[3]) @(negedge clk);
    push_raw(w);
    exp_q.push_back(w);
  endtask

  task automatic set_ring(input logic [DW-1:0] lo, input logic [DW-1:0] hi,
                          input logic [DW-1:0] p);
    ram[0] = lo; ram[1] = hi; ram[2] = p; ram[3] = p;
    ref_min = lo; ref_max = hi; ref_stop = p;
  endtask

  task automatic wait_drain(input string tag);
    int n;
    n = 0;
    while (!((exp_q.size() == 0) && (ram[3] == ram[2])) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, tag, 32'(exp_q.size()), 0);
  endtask

  task automatic quiet_window(input int n);
    quiet_hits = 0;
    quiet = 1'b1;
    repeat (n) @(negedge clk);
    quiet = 1'b0;
  endtask

  logic [DW-1:0] bad_off;

  initial begin
    for (int i = 0; i < 2**AW; i++) ram[i] = '0;
    set_ring(32'd16, 32'd16 + 32'd10240, 32'd16);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!cmd_valid, "R1 cmd_valid", 32'(cmd_valid), 0);
    check(!busy, "R1 busy", 32'(busy), 0);
    check(!err, "R1 err", 32'(err), 0);
    check(!mem_en && !mem_we, "R1 mem strobes", 32'({mem_en, mem_we}), 0);

    // R7 suspended while cfg_done low
    push(32'h0100_0001);
    push(32'h0F00_0002);
    push(32'h0000_0003);
    quiet_window(40);
    check(quiet_hits == 0, "R7 no emission when suspended", 32'(quiet_hits), 0);
    check(ram[3] == 32'd16, "R7 read pointer unchanged", ram[3], 32'd16);

    // R2/R3 consume after enable, producer updates picked up on later polls
    cfg_done = 1'b1;
    wait_drain("R3 drain of first batch");
    check(ram[3] == 32'd28, "R2 read pointer after three words", ram[3], 32'd28);
    push(32'h0500_0004);
    wait_drain("R2 late producer word seen");
    quiet_window(30);
    check(quiet_hits == 0, "R2 empty queue emits nothing", 32'(quiet_hits), 0);
    check(ram[3] == 32'd32, "R2 no write on empty queue", ram[3], 32'd32);

    // R10 sync with pending words, under backpressure (R4)
    stall_en = 1'b1;
    for (int i = 0; i < 5; i++) push(32'h0200_0010 + 32'(i));
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    check(busy, "R10 busy raised", 32'(busy), 1);
    begin
      int n;
      n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
    end
    check(exp_q.size() == 0, "R10 busy fell only after drain", 32'(exp_q.size()), 0);
    check(ram[3] == ram[2], "R10 pointers equal at busy fall", ram[3], ram[2]);

    // R10 sync on an empty queue
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    check(busy, "R10 busy raised on empty", 32'(busy), 1);
    repeat (40) @(negedge clk);
    check(!busy, "R10 busy released on empty", 32'(busy), 0);

    // R6 wrap with a full short ring
    cfg_done = 1'b0;
    repeat (4) @(negedge clk);
    set_ring(32'd64, 32'd96, 32'd88);
    for (int i = 0; i < 7; i++) push(32'h0300_0020 + 32'(i));
    check(ram[2] == 32'd84, "R6 producer wrapped to full", ram[2], 32'd84);
    cfg_done = 1'b1;
    wait_drain("R6 drain across wrap");
    check(ram[3] == 32'd84, "R6 read pointer after wrap", ram[3], 32'd84);
    stall_en = 1'b0;

    // R8 unrecognised opcode
    bad_off = ram[2];
    push_raw(32'h1000_0BAD);
    push(32'h0F00_0030);
    quiet_window(60);
    check(quiet_hits == 0, "R8 bad word not emitted", 32'(quiet_hits), 0);
    check(err, "R8 err set", 32'(err), 1);
    check(ram[3] == bad_off, "R8 bad word not consumed", ram[3], bad_off);
    repeat (20) @(negedge clk);
    check(err && ram[3] == bad_off, "R9 err sticky, halted", ram[3], bad_off);

    // R9 clear through cfg_done and resume
    cfg_done = 1'b0;
    repeat (2) @(negedge clk);
    check(!err, "R9 err cleared by cfg_done low", 32'(err), 0);
    ram[bad_off[AW+1:2]] = 32'h0700_0031;
    exp_q.push_front(32'h0700_0031);
    cfg_done = 1'b1;
    wait_drain("R9 resume after clear");
    check(!err, "R9 no error after repair", 32'(err), 0);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule